// File: doc/BRIEF.md
# Value-Indexed Indirect Jump Target Predictor

This block predicts the destination of indirect jumps by keying a direct-mapped target table on two things together: the jump's own PC and a data value produced earlier by a producer instruction that software has marked. The marking is a signed word offset carried in the jump's encoding. It points backwards or forwards from the jump to the producer. A sixteen-entry side table remembers, per static jump, where its producer sits and the last value that producer wrote back.

At fetch, a jump reads the remembered value, mixes it with its PC and reads the target table. Any other fetched instruction is compared against the stored producer PCs, and a match flags it as a producer. The pipeline carries that flag and the returned slot number to write-back. There the producer's result is written into the side table. If a jump has already predicted with an older value and the written value differs, a second lookup is made and a redirect is issued ahead of jump resolution. At commit, the pipeline returns the jump PC, the index the predictor used and the real target. The table entry is rewritten only if it does not already hold that target.

Top module: `vtp_predictor`

## Requirements
- R1: After reset no prediction or redirect is presented, and every table entry is invalid, so the first fetch of any jump misses.
- R2: A jump selects side-table slot PC[5:2]. If that slot holds the same jump PC, its stored value is used. Otherwise the slot is reallocated to this jump with value 0, and the producer PC is set to the jump PC plus four times the signed `f_off`.
- R3: One cycle after a fetch, `p_index` equals the 12-bit word (PC[13:2] XOR value[11:0]) folded to the index width, where bit i of the word is XORed into index bit (i mod index width).
- R4: A table entry hits only when it is valid and its stored tag equals PC[14+TAG_W-1:14] of the jump. On a miss, or for a non-jump, `p_hit` is 0 and `p_target` is the PC plus 4.
- R5: When a fetched non-jump's PC equals the producer PC of a valid slot, `p_is_hint` is 1 one cycle later and `p_hint_slot` gives that slot (the lowest such slot if several match). Otherwise `p_is_hint` is 0.
- R6: A write-back writes `w_value` into slot `w_slot`, and later jumps of that slot use it.
- R7: A commit leaves the entry at `c_index` holding `c_target` under the tag of `c_pc`, so a later fetch of that jump with the same value hits with that target.
- R8: When a write-back reaches a slot whose jump is in flight and the value differs from the one that jump used, one cycle later `r_valid` is 1. `r_pc` is the jump PC, `r_index` is the index recomputed with the new value, and `r_hit`/`r_target` come from a table lookup at that index (PC plus 4 on a miss).
- R9: A commit of a slot's jump ends its in-flight state, so later write-backs to that slot raise no redirect.
- R10: When a jump fetch and a write-back hit the same slot in one cycle, the prediction uses the old value. A redirect for the new value appears in the same output cycle as that prediction.
- R11: After a redirect, the in-flight jump is taken to hold the new value, so a repeat write-back of that same value raises no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid | input | 1 | Fetch lookup request |
| f_pc | input | 32 | Fetched instruction PC |
| f_is_jump | input | 1 | Fetched instruction is an indirect jump |
| f_off | input | 8 | Signed word offset from the jump to its producer |
| w_valid | input | 1 | Write-back of a flagged producer |
| w_slot | input | 4 | Side-table slot returned at fetch |
| w_value | input | 32 | Producer result |
| c_valid | input | 1 | Jump commit |
| c_pc | input | 32 | Committed jump PC |
| c_index | input | 6 | Table index used for that jump |
| c_target | input | 32 | Resolved target |
| p_valid | output | 1 | Fetch response valid |
| p_hit | output | 1 | Table hit for a jump |
| p_target | output | 32 | Predicted target or fall-through |
| p_index | output | 6 | Table index used |
| p_is_hint | output | 1 | Instruction is a producer |
| p_hint_slot | output | 4 | Producer's side-table slot |
| r_valid | output | 1 | Override redirect |
| r_pc | output | 32 | Jump PC being overridden |
| r_hit | output | 1 | Override lookup hit |
| r_target | output | 32 | Override target |
| r_index | output | 6 | Index for the overriding prediction |

## Verification
The assertions assume that write-back is only raised for a slot that a producer fetch actually returned. They also assume that a commit carries the index issued for that jump, and that inputs are quiet during reset. The stimulus follows this by always taking `w_slot` and `c_index` from values the bench has computed for the sequence it drives. It never lets a jump reallocation and a write-back to the same slot share a cycle. A sweep over all sixteen slots uses positive offsets that give distinct producer PCs, so the lowest-slot priority never has to break a tie.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
    localparam int PC_W   = 32;
    localparam int VAL_W  = 32;
    localparam int HASH_W = 12;
    localparam int WORD_LSB = 2;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [VAL_W-1:0] val_t;

    typedef struct packed {
        logic vld;
        pc_t  jmp_pc;
        pc_t  hint_pc;
        val_t value;
    } hib_ent_t;

    typedef struct packed {
        logic hit;
        pc_t  target;
    } tgt_rsp_t;

    function automatic logic [HASH_W-1:0] mix(pc_t pc, val_t v);
        return pc[HASH_W+WORD_LSB-1:WORD_LSB] ^ v[HASH_W-1:0];
    endfunction
endpackage

// File: rtl/vtp_hint_buf.sv
module vtp_hint_buf
    import vtp_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             f_valid,
    input  pc_t              f_pc,
    input  logic             f_is_jump,
    input  logic [OFF_W-1:0] f_off,
    input  logic             w_valid,
    input  logic [IDX_W-1:0] w_slot,
    input  val_t             w_value,
    input  logic             c_valid,
    input  pc_t              c_pc,
    output val_t             use_val,
    output logic             hint_hit,
    output logic [IDX_W-1:0] hint_slot,
    output logic             ovr_fire,
    output pc_t              ovr_pc,
    output val_t             ovr_val
);
    localparam int N = 1 << IDX_W;

    hib_ent_t ent  [N];
    logic     pend [N];
    val_t     used [N];

    logic [IDX_W-1:0] fslot, cslot;
    logic fj, fmatch, alloc, wb_ok, fresh_jump, watched;
    val_t prior;
    pc_t  new_hint_pc;

    always_comb begin
        fslot  = f_pc[WORD_LSB +: IDX_W];
        cslot  = c_pc[WORD_LSB +: IDX_W];
        fj     = f_valid && f_is_jump;
        fmatch = ent[fslot].vld && (ent[fslot].jmp_pc == f_pc);
        alloc  = fj && !fmatch;
        use_val = fmatch ? ent[fslot].value : '0;
        new_hint_pc = f_pc + {{(PC_W-OFF_W-WORD_LSB){f_off[OFF_W-1]}}, f_off, 2'b00};

        hint_hit  = 1'b0;
        hint_slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (f_valid && !f_is_jump && ent[i].vld && ent[i].hint_pc == f_pc) begin
                hint_hit  = 1'b1;
                hint_slot = i[IDX_W-1:0];
            end
        end

        wb_ok      = w_valid && ent[w_slot].vld && !(alloc && fslot == w_slot);
        fresh_jump = fj && (fslot == w_slot);
        watched    = fresh_jump || pend[w_slot];
        prior      = fresh_jump ? use_val : used[w_slot];
        ovr_fire   = wb_ok && watched && (w_value != prior);
        ovr_pc     = ent[w_slot].jmp_pc;
        ovr_val    = w_value;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                ent[i].vld <= 1'b0;
                pend[i]    <= 1'b0;
            end
        end else begin
            if (c_valid && ent[cslot].vld && ent[cslot].jmp_pc == c_pc)
                pend[cslot] <= 1'b0;
            if (fj) begin
                pend[fslot] <= 1'b1;
                used[fslot] <= use_val;
                if (alloc) begin
                    ent[fslot].vld     <= 1'b1;
                    ent[fslot].jmp_pc  <= f_pc;
                    ent[fslot].hint_pc <= new_hint_pc;
                    ent[fslot].value   <= '0;
                end
            end
            if (wb_ok) begin
                ent[w_slot].value <= w_value;
                if (watched)
                    used[w_slot] <= w_value;
            end
        end
    end

    // R8: a jump fetch leaves its slot in flight
    a_r8_fetch_sets_pending: assert property (@(posedge clk) disable iff (rst)
        fj |=> pend[$past(fslot)]);
    // R2: after a jump fetch its slot belongs to that jump
    a_r2_slot_owned: assert property (@(posedge clk) disable iff (rst)
        fj |=> ent[$past(fslot)].vld && ent[$past(fslot)].jmp_pc == $past(f_pc));
    // R11: after an override the recorded value is the new one
    a_r11_used_tracks: assert property (@(posedge clk) disable iff (rst)
        ovr_fire |=> used[$past(w_slot)] == $past(w_value));
endmodule

// File: rtl/vtp_target_buf.sv
module vtp_target_buf
    import vtp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pc_t              ra_pc,
    input  logic [IDX_W-1:0] ra_idx,
    output tgt_rsp_t         ra_rsp,
    input  pc_t              rb_pc,
    input  logic [IDX_W-1:0] rb_idx,
    output tgt_rsp_t         rb_rsp,
    input  logic             c_valid,
    input  pc_t              c_pc,
    input  logic [IDX_W-1:0] c_idx,
    input  pc_t              c_target
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int TAG_LSB = HASH_W + WORD_LSB;

    logic             vld [DEPTH];
    logic [TAG_W-1:0] tag [DEPTH];
    pc_t              tgt [DEPTH];

    logic need_wr;

    always_comb begin
        ra_rsp.hit    = vld[ra_idx] && tag[ra_idx] == ra_pc[TAG_LSB +: TAG_W];
        ra_rsp.target = ra_rsp.hit ? tgt[ra_idx] : ra_pc + 32'd4;
        rb_rsp.hit    = vld[rb_idx] && tag[rb_idx] == rb_pc[TAG_LSB +: TAG_W];
        rb_rsp.target = rb_rsp.hit ? tgt[rb_idx] : rb_pc + 32'd4;
        need_wr = c_valid && !(vld[c_idx] && tag[c_idx] == c_pc[TAG_LSB +: TAG_W]
                               && tgt[c_idx] == c_target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) vld[i] <= 1'b0;
        end else if (need_wr) begin
            vld[c_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (need_wr) begin
            tag[c_idx] <= c_pc[TAG_LSB +: TAG_W];
            tgt[c_idx] <= c_target;
        end
    end

    // R7: after a commit the entry holds the resolved target
    a_r7_commit_lands: assert property (@(posedge clk) disable iff (rst)
        c_valid |=> vld[$past(c_idx)] && tgt[$past(c_idx)] == $past(c_target));
endmodule

// File: rtl/vtp_predictor.sv
module vtp_predictor
    import vtp_pkg::*;
#(
    parameter int HIB_IDX_W = 4,
    parameter int TB_IDX_W  = 6,
    parameter int TAG_W     = 8,
    parameter int OFF_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 f_valid,
    input  logic [31:0]          f_pc,
    input  logic                 f_is_jump,
    input  logic [OFF_W-1:0]     f_off,
    input  logic                 w_valid,
    input  logic [HIB_IDX_W-1:0] w_slot,
    input  logic [31:0]          w_value,
    input  logic                 c_valid,
    input  logic [31:0]          c_pc,
    input  logic [TB_IDX_W-1:0]  c_index,
    input  logic [31:0]          c_target,
    output logic                 p_valid,
    output logic                 p_hit,
    output logic [31:0]          p_target,
    output logic [TB_IDX_W-1:0]  p_index,
    output logic                 p_is_hint,
    output logic [HIB_IDX_W-1:0] p_hint_slot,
    output logic                 r_valid,
    output logic [31:0]          r_pc,
    output logic                 r_hit,
    output logic [31:0]          r_target,
    output logic [TB_IDX_W-1:0]  r_index
);
    function automatic logic [TB_IDX_W-1:0] fold(logic [HASH_W-1:0] h);
        logic [TB_IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < HASH_W; i++) r[i % TB_IDX_W] = r[i % TB_IDX_W] ^ h[i];
        return r;
    endfunction

    val_t use_val, ovr_val;
    pc_t  ovr_pc;
    logic hint_hit, ovr_fire;
    logic [HIB_IDX_W-1:0] hint_slot;
    logic [TB_IDX_W-1:0]  idx_f, idx_o;
    tgt_rsp_t rsp_f, rsp_o;

    vtp_hint_buf #(.IDX_W(HIB_IDX_W), .OFF_W(OFF_W)) u_hib (
        .clk(clk), .rst(rst),
        .f_valid(f_valid), .f_pc(f_pc), .f_is_jump(f_is_jump), .f_off(f_off),
        .w_valid(w_valid), .w_slot(w_slot), .w_value(w_value),
        .c_valid(c_valid), .c_pc(c_pc),
        .use_val(use_val), .hint_hit(hint_hit), .hint_slot(hint_slot),
        .ovr_fire(ovr_fire), .ovr_pc(ovr_pc), .ovr_val(ovr_val)
    );

    always_comb begin
        idx_f = fold(mix(f_pc, use_val));
        idx_o = fold(mix(ovr_pc, ovr_val));
    end

    vtp_target_buf #(.IDX_W(TB_IDX_W), .TAG_W(TAG_W)) u_tb (
        .clk(clk), .rst(rst),
        .ra_pc(f_pc), .ra_idx(idx_f), .ra_rsp(rsp_f),
        .rb_pc(ovr_pc), .rb_idx(idx_o), .rb_rsp(rsp_o),
        .c_valid(c_valid), .c_pc(c_pc), .c_idx(c_index), .c_target(c_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p_valid <= 1'b0; p_hit <= 1'b0; p_target <= '0; p_index <= '0;
            p_is_hint <= 1'b0; p_hint_slot <= '0;
            r_valid <= 1'b0; r_pc <= '0; r_hit <= 1'b0; r_target <= '0; r_index <= '0;
        end else begin
            p_valid     <= f_valid;
            p_hit       <= f_valid && f_is_jump && rsp_f.hit;
            p_target    <= (f_is_jump && rsp_f.hit) ? rsp_f.target : f_pc + 32'd4;
            p_index     <= idx_f;
            p_is_hint   <= hint_hit;
            p_hint_slot <= hint_slot;
            r_valid     <= ovr_fire;
            r_pc        <= ovr_pc;
            r_hit       <= rsp_o.hit;
            r_target    <= rsp_o.target;
            r_index     <= idx_o;
        end
    end

    // R4: a miss falls through to the next word
    a_r4_miss_fallthrough: assert property (@(posedge clk) disable iff (rst)
        p_valid && !p_hit |-> p_target == $past(f_pc) + 32'd4);
    // R5: a jump is never flagged as a producer
    a_r5_hint_not_jump: assert property (@(posedge clk) disable iff (rst)
        p_is_hint |-> $past(f_valid) && !$past(f_is_jump));
    // R8: a redirect only follows a write-back
    a_r8_redirect_needs_wb: assert property (@(posedge clk) disable iff (rst)
        r_valid |-> $past(w_valid));
    // R1: no response without a request
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(f_valid) |-> !p_valid && !p_is_hint);
endmodule

// File: tb/sim_vtp_predictor.sv
module sim_vtp_predictor;
    logic clk = 0, rst = 1;
    always #5 clk = ~clk;

    logic f_valid = 0, f_is_jump = 0, w_valid = 0, c_valid = 0;
    logic [31:0] f_pc = 0, w_value = 0, c_pc = 0, c_target = 0;
    logic [7:0] f_off = 0;
    logic [3:0] w_slot = 0;
    logic [5:0] c_index = 0;
    logic p_valid, p_hit, p_is_hint, r_valid, r_hit;
    logic [31:0] p_target, r_pc, r_target;
    logic [5:0] p_index, r_index;
    logic [3:0] p_hint_slot;

    int total = 0, bad = 0;
    bit done = 0;

    vtp_predictor u0 (
        .clk(clk), .rst(rst), .f_valid(f_valid), .f_pc(f_pc), .f_is_jump(f_is_jump),
        .f_off(f_off), .w_valid(w_valid), .w_slot(w_slot), .w_value(w_value),
        .c_valid(c_valid), .c_pc(c_pc), .c_index(c_index), .c_target(c_target),
        .p_valid(p_valid), .p_hit(p_hit), .p_target(p_target), .p_index(p_index),
        .p_is_hint(p_is_hint), .p_hint_slot(p_hint_slot), .r_valid(r_valid),
        .r_pc(r_pc), .r_hit(r_hit), .r_target(r_target), .r_index(r_index)
    );

    function automatic logic [5:0] idx(logic [31:0] pc, logic [31:0] v);
        logic [11:0] h;
        logic [5:0] r;
        h = pc[13:2] ^ v[11:0];
        r = h[5:0] ^ h[11:6];
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        f_valid = 0; f_is_jump = 0; w_valid = 0; c_valid = 0;
    endtask

    task automatic fetch(logic [31:0] pc, logic jmp, logic [7:0] off);
        f_valid = 1; f_pc = pc; f_is_jump = jmp; f_off = off;
    endtask
    task automatic wb(logic [3:0] s, logic [31:0] v);
        w_valid = 1; w_slot = s; w_value = v;
    endtask
    task automatic commit(logic [31:0] pc, logic [5:0] i, logic [31:0] t);
        c_valid = 1; c_pc = pc; c_index = i; c_target = t;
    endtask

    localparam logic [31:0] A  = 32'h0000_1010;
    localparam logic [31:0] B  = 32'h0000_5010;
    localparam logic [31:0] T1 = 32'h0000_8000;
    localparam logic [31:0] T2 = 32'h0000_9000;
    localparam logic [31:0] V1 = 32'h0000_0035;
    localparam logic [31:0] V2 = 32'h0000_0077;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 p_valid", p_valid, 0);
        chk("R1 r_valid", r_valid, 0);

        fetch(A, 1, 8'hFD); step();
        chk("R1 first miss", p_hit, 0);
        chk("R4 fallthrough", p_target, A + 4);
        chk("R3 index v0", p_index, idx(A, 0));

        commit(A, idx(A, 0), T1); step();
        fetch(A, 1, 8'hFD); step();
        chk("R7 hit", p_hit, 1);
        chk("R7 target", p_target, T1);

        fetch(32'h1004, 0, 0); step();
        chk("R5 flag", p_is_hint, 1);
        chk("R5 slot", p_hint_slot, 4);
        fetch(32'h1008, 0, 0); step();
        chk("R5 no flag", p_is_hint, 0);

        wb(4, V1); step();
        chk("R8 redirect", r_valid, 1);
        chk("R8 pc", r_pc, A);
        chk("R8 index", r_index, idx(A, V1));
        chk("R8 miss target", r_target, A + 4);

        wb(4, V1); step();
        chk("R11 same value", r_valid, 0);

        commit(A, idx(A, V1), T2); step();
        wb(4, V2); step();
        chk("R9 after commit", r_valid, 0);

        fetch(A, 1, 8'hFD); step();
        chk("R6 uses value", p_index, idx(A, V2));
        chk("R6 miss", p_hit, 0);
        wb(4, V1); step();
        chk("R8 hit redirect", r_valid, 1);
        chk("R8 hit", r_hit, 1);
        chk("R8 hit target", r_target, T2);

        commit(A, idx(A, V1), T2); step();
        fetch(A, 1, 8'hFD); step();
        chk("R7 unchanged", p_target, T2);
        commit(A, idx(A, V1), T2); step();

        fetch(A, 1, 8'hFD); wb(4, V2); step();
        chk("R10 old index", p_index, idx(A, V1));
        chk("R10 old hit", p_target, T2);
        chk("R10 redirect", r_valid, 1);
        chk("R10 new index", r_index, idx(A, V2));
        commit(A, idx(A, V2), T1); step();

        fetch(B, 1, 8'hFD); step();
        chk("R4 tag miss", p_hit, 0);
        chk("R4 tag target", p_target, B + 4);
        chk("R2 realloc value", p_index, idx(B, 0));
        fetch(32'h5004, 0, 0); step();
        chk("R2 new hint pc", p_is_hint, 1);
        fetch(32'h1004, 0, 0); step();
        chk("R2 old hint gone", p_is_hint, 0);
        commit(B, idx(B, 0), T1); step();

        for (int k = 0; k < 16; k++) begin
            logic [31:0] pc, v;
            pc = 32'h2000 + 4 * k;
            v  = 16 * k + 1;
            fetch(pc, 1, k[7:0]); step();
            chk("R3 sweep index", p_index, idx(pc, 0));
            fetch(pc + 4 * k, 0, 0); step();
            chk("R5 sweep flag", p_is_hint, 1);
            chk("R5 sweep slot", p_hint_slot, k);
            wb(p_hint_slot, v); step();
            chk("R8 sweep redirect", r_valid, 1);
            chk("R8 sweep index", r_index, idx(pc, v));
            commit(pc, idx(pc, v), 32'h7000 + k); step();
            fetch(pc, 1, k[7:0]); step();
            chk("R7 sweep target", p_target, 32'h7000 + k);
            commit(pc, idx(pc, v), 32'h7000 + k); step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule